// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and presents them to a processor core on two request outputs: a normal interrupt request and a fast interrupt request. Each line is sampled every clock into a raw pending view. A per-source enable register gates the lines. A per-source class register then sends each enabled line to one of the two outputs. Software reads the raw view and one masked view per output class through a small register window. There is no acknowledge path: a pending bit clears as soon as its source line drops.

A one-bit wake-mode setting decides how pending lines end a wait-for-interrupt idle state. The registered wake output follows either the enabled lines only or every raw line. The enable, class and wake-mode settings can be read back exactly as written, so software can save them before a power transition and restore them afterwards.

Top module: `dual_intc`

## Requirements
- R1: After reset the enable (0x04), class (0x08) and wake-mode (0x0C) registers read zero, and irq_o, fiq_o and wake_o are low.
- R2: The enable and class registers store and return all 32 written bits. The wake-mode register stores bit 0 only, and bits 31..1 read zero.
- R3: The raw view at offset 0x20 shows src_i as sampled at the previous rising clock edge. A bit clears one cycle after its source drops, with no acknowledge.
- R4: The IRQ pending view at offset 0x00 equals raw AND enable AND NOT class, so a class bit of 0 means normal IRQ.
- R5: The FIQ pending view at offset 0x10 equals raw AND enable AND class, so a class bit of 1 means fast FIQ.
- R6: irq_o is high exactly when some source is enabled, has class 0 and was asserted at the previous edge. It is registered, so it follows a source change after one clock.
- R7: fiq_o is high exactly when some source is enabled, has class 1 and was asserted at the previous edge. It is registered the same way as irq_o.
- R8: With wake-mode bit 0 set, wake_o is high one clock after any enabled source is asserted, and it stays low while only disabled sources are asserted.
- R9: With wake-mode bit 0 clear, wake_o is high one clock after any source is asserted, whatever the enable register holds.
- R10: Writes to offsets 0x00, 0x10 and 0x20 change no register or view. Reads from any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x20 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| wr_en_i | input | 1 | Register write strobe, taken at the rising edge |
| addr_i | input | 6 | Byte offset into the register window |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wake request |

## Verification
The hardest situation to reach is wake-mode 1 with only disabled sources asserted. From the outside it looks the same as an idle controller, yet with wake-mode 0 the same line pattern must raise wake_o. The stimulus table drives that exact source and enable pattern twice, once with each wake-mode value, and checks that only wake_o differs. The stimulus also writes all ones to every read-only offset between readbacks, which shows that pending views and settings survive writes that a careless decoder would accept.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;
    // Register window byte offsets
    localparam int unsigned OFS_IRQ_PEND = 'h00;
    localparam int unsigned OFS_ENABLE   = 'h04;
    localparam int unsigned OFS_CLASS    = 'h08;
    localparam int unsigned OFS_WAKEMODE = 'h0C;
    localparam int unsigned OFS_FIQ_PEND = 'h10;
    localparam int unsigned OFS_RAW      = 'h20;
endpackage

// File: rtl/dual_intc_regs.sv
module dual_intc_regs
    import dual_intc_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wdata_i,
    input  logic [N_SRC-1:0]  raw_i,
    input  logic [N_SRC-1:0]  irq_pend_i,
    input  logic [N_SRC-1:0]  fiq_pend_i,
    output logic [N_SRC-1:0]  enable_o,
    output logic [N_SRC-1:0]  class_o,
    output logic              wake_mode_o,
    output logic [N_SRC-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_IRQP = ADDR_W'(OFS_IRQ_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_CLS  = ADDR_W'(OFS_CLASS);
    localparam logic [ADDR_W-1:0] A_WM   = ADDR_W'(OFS_WAKEMODE);
    localparam logic [ADDR_W-1:0] A_FIQP = ADDR_W'(OFS_FIQ_PEND);
    localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);

    typedef struct packed {
        logic [N_SRC-1:0] enable;
        logic [N_SRC-1:0] cls;
        logic             wake_mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (addr_i)
                A_EN:    cfg_d.enable    = wdata_i;
                A_CLS:   cfg_d.cls       = wdata_i;
                A_WM:    cfg_d.wake_mode = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr_i)
            A_IRQP:  rdata_o = irq_pend_i;
            A_EN:    rdata_o = cfg_q.enable;
            A_CLS:   rdata_o = cfg_q.cls;
            A_WM:    rdata_o = {{(N_SRC-1){1'b0}}, cfg_q.wake_mode};
            A_FIQP:  rdata_o = fiq_pend_i;
            A_RAW:   rdata_o = raw_i;
            default: rdata_o = '0;
        endcase
    end

    assign enable_o    = cfg_q.enable;
    assign class_o     = cfg_q.cls;
    assign wake_mode_o = cfg_q.wake_mode;

    assert_enable_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_EN) |=> (enable_o == $past(wdata_i)));

    assert_class_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_CLS) |=> (class_o == $past(wdata_i)));

    assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == A_IRQP || addr_i == A_FIQP || addr_i == A_RAW))
        |=> ($stable(enable_o) && $stable(class_o) && $stable(wake_mode_o)));
endmodule

// File: rtl/dual_intc_route.sv
module dual_intc_route #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] enable_i,
    input  logic [N_SRC-1:0] class_i,
    input  logic             wake_mode_i,
    output logic [N_SRC-1:0] raw_o,
    output logic [N_SRC-1:0] irq_pend_o,
    output logic [N_SRC-1:0] fiq_pend_o,
    output logic             irq_o,
    output logic             fiq_o,
    output logic             wake_o
);
    typedef struct packed {
        logic [N_SRC-1:0] raw;
        logic             irq;
        logic             fiq;
        logic             wake;
    } st_t;

    st_t st_d, st_q;
    logic [N_SRC-1:0] live_en;

    always_comb begin
        live_en      = src_i & enable_i;
        st_d.raw     = src_i;
        st_d.irq     = |(live_en & ~class_i);
        st_d.fiq     = |(live_en & class_i);
        st_d.wake    = wake_mode_i ? (|live_en) : (|src_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o      = st_q.raw;
    assign irq_pend_o = st_q.raw & enable_i & ~class_i;
    assign fiq_pend_o = st_q.raw & enable_i & class_i;
    assign irq_o      = st_q.irq;
    assign fiq_o      = st_q.fiq;
    assign wake_o     = st_q.wake;

    assert_quiet_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> (!irq_o && !fiq_o));

    assert_no_fiq_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (class_i == '0) |=> !fiq_o);

    assert_masked_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mode_i && enable_i == '0) |=> !wake_o);

    assert_raw_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_mode_i && src_i != '0) |=> wake_o);

    assert_req_implies_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> wake_o);
endmodule

// File: rtl/dual_intc.sv
module dual_intc #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);
    logic [N_SRC-1:0] enable_w, class_w, raw_w, irqp_w, fiqp_w;
    logic             wake_mode_w;

    dual_intc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .raw_i       (raw_w),
        .irq_pend_i  (irqp_w),
        .fiq_pend_i  (fiqp_w),
        .enable_o    (enable_w),
        .class_o     (class_w),
        .wake_mode_o (wake_mode_w),
        .rdata_o     (rdata_o)
    );

    dual_intc_route #(.N_SRC(N_SRC)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .enable_i    (enable_w),
        .class_i     (class_w),
        .wake_mode_i (wake_mode_w),
        .raw_o       (raw_w),
        .irq_pend_o  (irqp_w),
        .fiq_pend_o  (fiqp_w),
        .irq_o       (irq_o),
        .fiq_o       (fiq_o),
        .wake_o      (wake_o)
    );
endmodule

// File: tb/dual_intc_bench.sv
`timescale 1ns/1ps
module dual_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, fiq_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dual_intc u_dual_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    // src, enable, class, wakemode, irq view, fiq view, irq, fiq, wake
    typedef struct packed {
        logic [31:0] src;
        logic [31:0] en;
        logic [31:0] cls;
        logic        wm;
        logic [31:0] irqp;
        logic [31:0] fiqp;
        logic        irq;
        logic        fiq;
        logic        wake;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_00FF, 32'h0000_000F, 32'h0000_0000, 1'b1, 32'h0000_000F, 32'h0000_0000, 1'b1, 1'b0, 1'b1},
        '{32'h0000_00FF, 32'h0000_00F0, 32'h0000_00C0, 1'b1, 32'h0000_0030, 32'h0000_00C0, 1'b1, 1'b1, 1'b1},
        '{32'h0000_FF00, 32'h0000_00FF, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        '{32'h0000_FF00, 32'h0000_00FF, 32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1},
        '{32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b1, 1'b1},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        '{32'hA5A5_0000, 32'hFF00_FF00, 32'h0F00_0F00, 1'b1, 32'hA000_0000, 32'h0500_0000, 1'b1, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(6'h04, d); check("R1 enable", d, 32'h0);
        rd(6'h08, d); check("R1 class", d, 32'h0);
        rd(6'h0C, d); check("R1 wakemode", d, 32'h0);
        check("R1 outputs", {29'b0, irq_o, fiq_o, wake_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: full readback
        wr(6'h04, 32'hDEAD_BEEF); rd(6'h04, d); check("R2 enable rw", d, 32'hDEAD_BEEF);
        wr(6'h08, 32'h5A5A_C3C3); rd(6'h08, d); check("R2 class rw", d, 32'h5A5A_C3C3);
        wr(6'h0C, 32'hFFFF_FFFF); rd(6'h0C, d); check("R2 wakemode bit0 only", d, 32'h1);
        wr(6'h0C, 32'hFFFF_FFFE); rd(6'h0C, d); check("R2 wakemode clear", d, 32'h0);

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            wr(6'h04, VECS[i].en);
            wr(6'h08, VECS[i].cls);
            wr(6'h0C, {31'b0, VECS[i].wm});
            src_i = VECS[i].src;
            @(negedge clk);
            rd(6'h20, d); check($sformatf("R3 raw v%0d", i), d, VECS[i].src);
            rd(6'h00, d); check($sformatf("R4 irq view v%0d", i), d, VECS[i].irqp);
            rd(6'h10, d); check($sformatf("R5 fiq view v%0d", i), d, VECS[i].fiqp);
            check($sformatf("R6 irq_o v%0d", i), {31'b0, irq_o}, {31'b0, VECS[i].irq});
            check($sformatf("R7 fiq_o v%0d", i), {31'b0, fiq_o}, {31'b0, VECS[i].fiq});
            check($sformatf("R8 R9 wake_o v%0d", i), {31'b0, wake_o}, {31'b0, VECS[i].wake});
        end

        // R10: writes to read-only views ignored, unmapped reads zero
        wr(6'h04, 32'h0000_00FF); wr(6'h08, 32'h0000_000F); wr(6'h0C, 32'h1);
        src_i = 32'h0000_0011;
        wr(6'h00, 32'hFFFF_FFFF); wr(6'h10, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF);
        rd(6'h04, d); check("R10 enable kept", d, 32'h0000_00FF);
        rd(6'h08, d); check("R10 class kept", d, 32'h0000_000F);
        rd(6'h0C, d); check("R10 wakemode kept", d, 32'h1);
        rd(6'h20, d); check("R10 raw kept", d, 32'h0000_0011);
        rd(6'h00, d); check("R10 irq view kept", d, 32'h0000_0010);
        rd(6'h10, d); check("R10 fiq view kept", d, 32'h0000_0001);
        rd(6'h14, d); check("R10 unmapped 0x14", d, 32'h0);
        rd(6'h3C, d); check("R10 unmapped 0x3C", d, 32'h0);

        // R3 R6: release without acknowledge, one-cycle latency
        wr(6'h08, 32'h0);
        src_i = 32'h0;
        @(negedge clk);
        rd(6'h20, d); check("R3 raw cleared", d, 32'h0);
        check("R6 irq_o dropped", {31'b0, irq_o}, 32'h0);
        src_i = 32'h0000_0004;
        #1; check("R6 irq_o before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R6 irq_o after one edge", {31'b0, irq_o}, 32'h1);
        // R7: steer same source to FIQ
        wr(6'h08, 32'h0000_0004);
        @(negedge clk);
        check("R7 fiq_o steered", {30'b0, irq_o, fiq_o}, 32'h1);
        // R8: disabled source, mode 1, no wake
        wr(6'h04, 32'h0);
        @(negedge clk);
        check("R8 disabled no wake", {31'b0, wake_o}, 32'h0);
        // R9: mode 0 wakes on raw
        wr(6'h0C, 32'h0);
        @(negedge clk);
        check("R9 raw wake", {31'b0, wake_o}, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule